// File: doc/BRIEF.md
# Beat-Note Lock Acquisition Controller

This block brings a phase-tracking loop from an unlocked start into lock without operator help. While enabled, it first measures the frequency of the digitized beat note. It counts the rising sign crossings of the samples over a fixed window of a power-of-two number of clocks. The count, scaled by a shift, gives an oscillator frequency word. The controller loads that word into the tracker, together with a clear of the tracker integrators. The loop then starts in a low-gain acquisition setting.

After the preset, the controller watches the tracker's in-phase and quadrature error samples. It raises the loop to the high-gain science setting once a run of good samples has passed: a small quadrature error and enough in-phase amplitude. Leaving lock needs a separate run of bad samples, so the lock decision has hysteresis. A loss of lock sends the controller back to measure the frequency again. The gain setting and the loop response profile (phase-lock or arm-lock) change only on a sample strobe. The integrators are not cleared when the gain switches, so the switch causes no step. The target offset frequency can be changed at run time. All outputs are registered, which keeps the latency to the tracker short.

Top module: `lock_acq_ctrl`

## Requirements
- R1: While `enable` is high, the controller leaves state IDLE (code 0) on the next clock. It then spends exactly 2^GATE_LOG2 clocks in COUNT (code 1) and one clock in PRESET (code 2), and then enters ACQUIRE (code 3). `acq_state` shows these codes.
- R2: The count is the number of clocks in the COUNT window on which a sample's sign bit (its MSB) is clear and the previous clock's sample was negative. `nco_word` becomes count << (FREQ_W-GATE_LOG2). `nco_load` is high for exactly one clock, which is the first ACQUIRE clock.
- R3: `offset_err` is `nco_word` minus `target_offset`, modulo 2^FREQ_W. The value of `target_offset` used is the one present during the PRESET clock.
- R4: `integ_clr` is high together with `nco_load` and at no other time. In particular, it stays low when the gain switches.
- R5: A sample is good when `err_vld` is high, |`err_q`| < `q_thresh` (strictly), and `err_i` >= `i_min` (signed). In ACQUIRE, the controller moves to LOCKED (code 4) and sets `gain_hi` on the first strobe that follows `lock_len` consecutive good samples. Any bad sample restarts the run.
- R6: In LOCKED, the controller returns to COUNT with `gain_hi` low on the first strobe that follows `unlock_len` consecutive bad samples. A shorter bad run, or one broken by a good sample, keeps the lock.
- R7: While `enable` is high, `gain_hi` changes only on a clock where `err_vld` is high.
- R8: `ctrl_profile` takes the value of `profile_sel` only on clocks where `err_vld` is high, and holds it otherwise.
- R9: With `enable` low, the controller is in IDLE with `gain_hi` low on the next clock, whatever state it was in.
- R10: After reset, `acq_state` is 0 and `gain_hi`, `nco_load`, `integ_clr` and `ctrl_profile` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the acquisition sequence |
| adc_sample | input | SAMP_W | Signed digitized beat note |
| err_vld | input | 1 | Strobe for a tracker error sample |
| err_i | input | ERR_W | Signed in-phase tracker output |
| err_q | input | ERR_W | Signed quadrature tracker error |
| target_offset | input | FREQ_W | Target offset frequency word |
| q_thresh | input | ERR_W | Quadrature magnitude bound for a good sample |
| i_min | input | ERR_W | Signed minimum in-phase amplitude |
| lock_len | input | RUN_W | Good samples needed to declare lock |
| unlock_len | input | RUN_W | Bad samples needed to drop lock |
| profile_sel | input | 1 | Requested response: 0 phase-lock, 1 arm-lock |
| acq_state | output | 3 | Controller state code |
| gain_hi | output | 1 | 1 selects science gain, 0 acquisition gain |
| ctrl_profile | output | 1 | Applied response profile |
| nco_load | output | 1 | One-clock load strobe for nco_word |
| nco_word | output | FREQ_W | Preset oscillator frequency word |
| offset_err | output | FREQ_W | Measured minus target frequency word |
| integ_clr | output | 1 | Clear for the tracker integrators |

## Verification
The bench builds the block with GATE_LOG2=6 and FREQ_W=24, so each count window is 64 clocks and the scaling shift is 18. Square-wave beat notes with periods of 2, 4, 8 and 16 clocks therefore give exact counts of 32, 16, 8 and 4 in any window position, and a whole frequency measurement fits in a few dozen clocks. RUN_W=8 is used with lock and unlock runs of 5 and 8. With these values, the strict quadrature bound, the in-phase floor and both sides of the hysteresis can each be reached in a handful of strobes.

// File: rtl/lock_acq_pkg.sv
package lock_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_COUNT  = 3'd1,
    ST_PRESET = 3'd2,
    ST_ACQ    = 3'd3,
    ST_LOCK   = 3'd4
  } acq_state_t;
endpackage

// File: rtl/edge_freq_counter.sv
module edge_freq_counter #(
  parameter int SAMP_W    = 12,
  parameter int GATE_LOG2 = 10,
  localparam int CNT_W    = GATE_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [SAMP_W-1:0] sample,
  output logic              done,
  output logic [CNT_W-1:0]  count
);
  logic                 prev_neg;
  logic [GATE_LOG2-1:0] gate;
  logic                 rise;

  assign rise = prev_neg & ~sample[SAMP_W-1];
  assign done = run & (&gate);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_neg <= 1'b0;
      gate     <= '0;
      count    <= '0;
    end else begin
      prev_neg <= sample[SAMP_W-1];
      if (run) begin
        gate  <= gate + 1'b1;
        count <= count + CNT_W'(rise);
      end else begin
        gate  <= '0;
        count <= '0;
      end
    end
  end

  AST_EDGES_WITHIN_GATE: assert property (@(posedge clk) disable iff (rst)
    count <= {1'b0, gate} || (&gate && count == {1'b1, {GATE_LOG2{1'b0}}}) || !run && $past(done)); // R2
endmodule

// File: rtl/lock_quality_det.sv
module lock_quality_det #(
  parameter int ERR_W = 16,
  parameter int RUN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    smp_vld,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic signed [ERR_W-1:0] err_q,
  input  logic        [ERR_W-1:0] q_thresh,
  input  logic signed [ERR_W-1:0] i_min,
  input  logic        [RUN_W-1:0] lock_len,
  input  logic        [RUN_W-1:0] unlock_len,
  output logic                    pass,
  output logic                    fail
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [ERR_W:0]   ONE     = {{ERR_W{1'b0}}, 1'b1};

  logic [ERR_W:0]   q_mag;
  logic             good;
  logic [RUN_W-1:0] good_run, bad_run;

  always_comb begin
    if (err_q[ERR_W-1]) q_mag = {1'b0, ~err_q} + ONE;
    else                q_mag = {1'b0, err_q};
    good = (q_mag < {1'b0, q_thresh}) && (err_i >= i_min);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      good_run <= '0;
      bad_run  <= '0;
    end else if (smp_vld) begin
      if (good) begin
        good_run <= (good_run == RUN_MAX) ? RUN_MAX : good_run + 1'b1;
        bad_run  <= '0;
      end else begin
        bad_run  <= (bad_run == RUN_MAX) ? RUN_MAX : bad_run + 1'b1;
        good_run <= '0;
      end
    end
  end

  assign pass = (good_run >= lock_len);
  assign fail = (bad_run >= unlock_len);

  AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(good_run != '0 && bad_run != '0)); // R5
  AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    smp_vld && !good |=> good_run == '0); // R5
endmodule

// File: rtl/lock_acq_ctrl.sv
module lock_acq_ctrl
  import lock_acq_pkg::*;
#(
  parameter int SAMP_W    = 12,
  parameter int ERR_W     = 16,
  parameter int GATE_LOG2 = 10,
  parameter int FREQ_W    = 32,
  parameter int RUN_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic [SAMP_W-1:0]        adc_sample,
  input  logic                     err_vld,
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic signed [ERR_W-1:0]  err_q,
  input  logic [FREQ_W-1:0]        target_offset,
  input  logic [ERR_W-1:0]         q_thresh,
  input  logic signed [ERR_W-1:0]  i_min,
  input  logic [RUN_W-1:0]         lock_len,
  input  logic [RUN_W-1:0]         unlock_len,
  input  logic                     profile_sel,
  output logic [2:0]               acq_state,
  output logic                     gain_hi,
  output logic                     ctrl_profile,
  output logic                     nco_load,
  output logic [FREQ_W-1:0]        nco_word,
  output logic [FREQ_W-1:0]        offset_err,
  output logic                     integ_clr
);
  localparam int CNT_W = GATE_LOG2 + 1;
  localparam int SHIFT = FREQ_W - GATE_LOG2;

  acq_state_t        state;
  logic              cnt_done;
  logic [CNT_W-1:0]  cnt_val;
  logic              det_pass, det_fail, det_clear;
  logic [FREQ_W-1:0] preset_w;

  assign det_clear = !(state == ST_ACQ || state == ST_LOCK);
  assign preset_w  = FREQ_W'(cnt_val) << SHIFT;
  assign acq_state = state;

  edge_freq_counter #(.SAMP_W(SAMP_W), .GATE_LOG2(GATE_LOG2)) i_cnt (
    .clk(clk), .rst(rst), .run(state == ST_COUNT), .sample(adc_sample),
    .done(cnt_done), .count(cnt_val)
  );

  lock_quality_det #(.ERR_W(ERR_W), .RUN_W(RUN_W)) i_det (
    .clk(clk), .rst(rst), .clear(det_clear), .smp_vld(err_vld),
    .err_i(err_i), .err_q(err_q), .q_thresh(q_thresh), .i_min(i_min),
    .lock_len(lock_len), .unlock_len(unlock_len),
    .pass(det_pass), .fail(det_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      gain_hi      <= 1'b0;
      ctrl_profile <= 1'b0;
      nco_load     <= 1'b0;
      integ_clr    <= 1'b0;
      nco_word     <= '0;
      offset_err   <= '0;
    end else begin
      nco_load  <= 1'b0;
      integ_clr <= 1'b0;
      if (err_vld) ctrl_profile <= profile_sel;
      if (!enable) begin
        state   <= ST_IDLE;
        gain_hi <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE:  state <= ST_COUNT;
          ST_COUNT: if (cnt_done) state <= ST_PRESET;
          ST_PRESET: begin
            nco_word   <= preset_w;
            offset_err <= preset_w - target_offset;
            nco_load   <= 1'b1;
            integ_clr  <= 1'b1;
            state      <= ST_ACQ;
          end
          ST_ACQ: if (err_vld && det_pass) begin
            state   <= ST_LOCK;
            gain_hi <= 1'b1;
          end
          ST_LOCK: if (err_vld && det_fail) begin
            state   <= ST_COUNT;
            gain_hi <= 1'b0;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_GAIN_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_hi) |-> $past(err_vld) || !$past(enable)); // R7
  AST_PROFILE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_profile) |-> $past(err_vld)); // R8
  AST_NO_CLEAR_AT_SWITCH: assert property (@(posedge clk) disable iff (rst)
    $rose(gain_hi) |-> !integ_clr); // R4
  AST_LOCK_FROM_ACQ: assert property (@(posedge clk) disable iff (rst)
    $rose(gain_hi) |-> $past(state) == ST_ACQ); // R5
  AST_LOAD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    nco_load |=> !nco_load); // R2
  AST_LOAD_ENTERS_ACQ: assert property (@(posedge clk) disable iff (rst)
    $rose(nco_load) |-> state == ST_ACQ); // R1
endmodule

// File: tb/test_lock_acq_ctrl.sv
module test_lock_acq_ctrl;
  localparam int CLK_NS    = 10;
  localparam int SAMP_W    = 12;
  localparam int ERR_W     = 16;
  localparam int GATE_LOG2 = 6;
  localparam int FREQ_W    = 24;
  localparam int RUN_W     = 8;
  localparam int NVEC      = 4;
  localparam int SH        = FREQ_W - GATE_LOG2;

  // each vector: beat period (clocks), target offset word
  localparam int VEC_PER [NVEC] = '{8, 4, 16, 2};
  localparam logic [FREQ_W-1:0] VEC_TGT [NVEC] = '{24'h000100, 24'h300000, 24'h000000, 24'h123456};

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, err_vld = 1'b0, profile_sel = 1'b0;
  logic [SAMP_W-1:0] adc_sample = '0;
  logic signed [ERR_W-1:0] err_i = '0, err_q = '0;
  logic [FREQ_W-1:0] target_offset = '0;
  logic [ERR_W-1:0] q_thresh = 16'd50;
  logic signed [ERR_W-1:0] i_min = 16'sd1000;
  logic [RUN_W-1:0] lock_len = 8'd5, unlock_len = 8'd8;
  logic [2:0] acq_state;
  logic gain_hi, ctrl_profile, nco_load, integ_clr;
  logic [FREQ_W-1:0] nco_word, offset_err;

  int errors = 0, checks = 0, per = 8, wcyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  lock_acq_ctrl #(.SAMP_W(SAMP_W), .ERR_W(ERR_W), .GATE_LOG2(GATE_LOG2),
                  .FREQ_W(FREQ_W), .RUN_W(RUN_W)) i_lock_acq_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .adc_sample(adc_sample),
    .err_vld(err_vld), .err_i(err_i), .err_q(err_q), .target_offset(target_offset),
    .q_thresh(q_thresh), .i_min(i_min), .lock_len(lock_len), .unlock_len(unlock_len),
    .profile_sel(profile_sel), .acq_state(acq_state), .gain_hi(gain_hi),
    .ctrl_profile(ctrl_profile), .nco_load(nco_load), .nco_word(nco_word),
    .offset_err(offset_err), .integ_clr(integ_clr)
  );

  // square-wave beat note, driven away from the active edge
  always @(negedge clk) begin
    wcyc <= wcyc + 1;
    adc_sample <= ((wcyc % per) < (per / 2)) ? 12'sd100 : -12'sd100;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int ii, input int qq);
    @(negedge clk);
    err_vld = 1'b1; err_i = ERR_W'(ii); err_q = ERR_W'(qq);
    @(negedge clk);
    err_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_to_acq(output int ncount, output int npre);
    ncount = 0; npre = 0;
    for (int g = 0; g < 400 && !nco_load; g++) begin
      @(negedge clk);
      if (acq_state == 3'd1) ncount++;
      if (acq_state == 3'd2) npre++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nc, np;
    longint expw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(acq_state == 3'd0, "R10 state", acq_state, 0);
    chk(gain_hi == 1'b0 && ctrl_profile == 1'b0, "R10 gain/profile", {gain_hi, ctrl_profile}, 0);
    chk(nco_load == 1'b0 && integ_clr == 1'b0, "R10 load/clear", {nco_load, integ_clr}, 0);

    // table of beat periods and targets
    for (int v = 0; v < NVEC; v++) begin
      per = VEC_PER[v];
      target_offset = VEC_TGT[v];
      repeat (4) @(negedge clk);
      enable = 1'b1;
      run_to_acq(nc, np);
      expw = longint'((64 / VEC_PER[v]) << SH);
      chk(nc == 64, "R1 count window", nc, 64);
      chk(np == 1, "R1 preset clocks", np, 1);
      chk(acq_state == 3'd3, "R1 acquire entered", acq_state, 3);
      chk(nco_word == FREQ_W'(expw), "R2 nco word", nco_word, expw);
      chk(offset_err == FREQ_W'(expw) - VEC_TGT[v], "R3 offset error", offset_err,
          longint'(FREQ_W'(FREQ_W'(expw) - VEC_TGT[v])));
      chk(integ_clr == 1'b1, "R4 clear with load", integ_clr, 1);
      @(negedge clk);
      chk(nco_load == 1'b0 && integ_clr == 1'b0, "R2 R4 single pulse", {nco_load, integ_clr}, 0);
      enable = 1'b0;
      @(negedge clk);
      chk(acq_state == 3'd0, "R9 disable to idle", acq_state, 0);
    end

    // lock sequence
    per = 8; target_offset = 24'h000200;
    enable = 1'b1;
    run_to_acq(nc, np);
    chk(gain_hi == 1'b0, "R5 low gain in acquire", gain_hi, 0);
    profile_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk(ctrl_profile == 1'b0, "R8 profile held without strobe", ctrl_profile, 0);
    strobe(2000, 10);
    chk(ctrl_profile == 1'b1, "R8 profile on strobe", ctrl_profile, 1);
    strobe(1000, -49);
    strobe(2000, 49);
    strobe(2000, 0);
    strobe(2000, -50);  // |Q| equal to bound is bad
    strobe(999, 0);     // I below floor is bad
    chk(acq_state == 3'd3, "R5 bad samples restart run", acq_state, 3);
    for (int k = 0; k < 5; k++) strobe(3000, 5);
    chk(acq_state == 3'd3 && gain_hi == 1'b0, "R5 no lock before next strobe", acq_state, 3);
    @(negedge clk);
    err_vld = 1'b1; err_i = 16'sd3000; err_q = 16'sd0;
    chk(gain_hi == 1'b0, "R7 gain before strobe edge", gain_hi, 0);
    @(negedge clk);
    err_vld = 1'b0;
    chk(acq_state == 3'd4 && gain_hi == 1'b1, "R5 lock declared", acq_state, 4);
    chk(integ_clr == 1'b0, "R4 no clear at gain switch", integ_clr, 0);
    repeat (3) @(negedge clk);

    // hysteresis on unlock
    for (int k = 0; k < 7; k++) strobe(0, 500);
    chk(acq_state == 3'd4, "R6 short bad run keeps lock", acq_state, 4);
    strobe(2000, 0);
    for (int k = 0; k < 8; k++) strobe(0, 500);
    chk(acq_state == 3'd4 && gain_hi == 1'b1, "R6 broken run keeps lock", acq_state, 4);
    strobe(0, 500);
    chk(acq_state == 3'd1 && gain_hi == 1'b0, "R6 unlock returns to count", acq_state, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(acq_state == 3'd0 && gain_hi == 1'b0, "R9 disable from count", acq_state, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule